// File: doc/BRIEF.md
# Two-Dimensional Transfer Address Sequencer

This block turns one transfer descriptor into the ordered stream of address pairs a DMA engine needs: a memory-side byte address and a peripheral-side address for every beat. A single start pulse latches the descriptor. The block then offers one beat at a time on a valid/ready pair and pulses `done` once the final beat has been taken. It does not move any data, swap bytes or drive a bus.

Two walk modes are supported. In linear mode the transfer is one run of equal-width beats. In 2D mode it is a set of rows. Each row has a fixed byte length, and a byte gap lies between the end of one row and the start of the next. The peripheral address either stays fixed or steps by 1, 2 or 4 bytes per beat. Beats are grouped into bursts, and between two bursts the block can hold off for a multiple of 256 cycles so that a slow peripheral can refill or drain its FIFO.

Top module: `dma2d_addr_gen`

## Requirements
- R1: Linear mode (`mode_2d`=0) issues exactly `xfer_len` beats. Beat i has memory address `mem_base` + i×W. W is the unit width from `unit_code`: 0→4 bytes, 1→2 bytes, 2→1 byte.
- R2: 2D mode (`mode_2d`=1) issues `row_count` × ceil(`row_bytes`/W) beats. Within a row the memory address rises by W per beat.
- R3: In 2D mode, each row starts at the previous row start plus `row_bytes` plus `line_gap`.
- R4: When `per_inc_en`=1, the peripheral address of global beat k is `per_base` + k×S. S comes from `per_step_code`: 2→1, 1→2, 0→4. The count k runs on across row boundaries.
- R5: When `per_inc_en`=0, every beat carries `per_base` as its peripheral address.
- R6: A burst holds `burst_code` beats, and a code of 0 gives one beat per burst. Between consecutive bursts, `beat_valid` stays low for exactly `delay_code`×256 cycles. There is no hold-off before the first burst.
- R7: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `mem_addr` and `per_addr` hold their values into the next cycle.
- R8: `done` is high for the single cycle right after the final beat is accepted, and `beat_valid` is never high together with `done`.
- R9: A descriptor with zero beats (linear `xfer_len`=0, or in 2D mode `row_count`=0 or `row_bytes`=0) raises `done` in the cycle after `start` and issues no beat.
- R10: A `start` pulse while a transfer is in progress has no effect on the remaining beats.
- R11: During reset, `beat_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Latch descriptor and begin when idle |
| mode_2d | input | 1 | 1 = row walk, 0 = linear |
| unit_code | input | 2 | Beat width code (0:4, 1:2, 2:1 bytes) |
| per_inc_en | input | 1 | Step the peripheral address each beat |
| per_step_code | input | 2 | Peripheral step code (2:1, 1:2, 0:4 bytes) |
| xfer_len | input | LEN_W | Linear beat count |
| row_count | input | ROWS_W | Number of rows in 2D mode |
| row_bytes | input | LEN_W | Bytes per row in 2D mode |
| line_gap | input | GAP_W | Bytes from a row end to the next row start |
| mem_base | input | ADDR_W | First memory byte address |
| per_base | input | ADDR_W | First peripheral address |
| delay_code | input | 3 | Hold-off between bursts, in units of 256 cycles |
| burst_code | input | 3 | Beats per burst (0 treated as 1) |
| beat_valid | output | 1 | Address pair is offered |
| beat_ready | input | 1 | Consumer takes the offered pair |
| mem_addr | output | ADDR_W | Memory byte address of the beat |
| per_addr | output | ADDR_W | Peripheral address of the beat |
| done | output | 1 | One-cycle completion pulse |

## Verification
The walk is exercised with:
- linear transfers at word and byte width;
- 2D transfers whose row length is a whole number of beats, and one whose row length is not, so that ceiling rounding is distinguished from truncation;
- a nonzero line gap, so that gap-from-row-end is distinguished from a full-stride interpretation.

Burst code 0 with a nonzero delay separates "zero means one" from "zero means no pacing". Mixed burst and delay codes check that the hold-off falls only between bursts and never before the first one.

A stalling ready pattern checks that an offered pair is held until taken. A start pulse injected mid-transfer, together with zero rows, zero row bytes and zero length, covers the ignore and immediate-completion paths.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } size_code_e;

  // Inverted size code shared by beat width and peripheral step.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (size_code_e'(code))
      SZ_WORD: return 3'd4;
      SZ_HALF: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // Beats needed to cover nbytes, rounding a partial beat up.
  function automatic int unsigned beats_for_bytes(input int unsigned nbytes,
                                                  input logic [1:0] code);
    case (size_code_e'(code))
      SZ_WORD: return (nbytes + 32'd3) >> 2;
      SZ_HALF: return (nbytes + 32'd1) >> 1;
      default: return nbytes;
    endcase
  endfunction

  // Burst length; a zero code still moves one beat per burst.
  function automatic logic [3:0] burst_beats(input logic [2:0] code);
    return (code == 3'd0) ? 4'd1 : {1'b0, code};
  endfunction

endpackage

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int ROWS_W = 12,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [1:0]        unit_code,
  input  logic              per_inc_en,
  input  logic [1:0]        per_step_code,
  input  logic [CNT_W-1:0]  beats_per_row,
  input  logic [ROWS_W-1:0] rows,
  input  logic [CNT_W-1:0]  row_bytes,
  input  logic [GAP_W-1:0]  line_gap,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] per_base,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] per_addr,
  output logic              last_beat,
  output logic              row_wrap,
  output logic              per_static
);
  import dma2d_pkg::*;

  logic [ADDR_W-1:0] row_start, row_adv_q;
  logic [2:0]        unit_q, pstep_q;
  logic [CNT_W-1:0]  bpr_q, col_left;
  logic [ROWS_W-1:0] rows_left;
  logic [ADDR_W-1:0] next_row;

  assign row_wrap   = (col_left == CNT_W'(1));
  assign last_beat  = row_wrap && (rows_left == ROWS_W'(1));
  assign per_static = (pstep_q == 3'd0);
  assign next_row   = row_start + row_adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      per_addr  <= '0;
      row_start <= '0;
      row_adv_q <= '0;
      unit_q    <= 3'd4;
      pstep_q   <= '0;
      bpr_q     <= '0;
      col_left  <= '0;
      rows_left <= '0;
    end else if (load) begin
      mem_addr  <= mem_base;
      row_start <= mem_base;
      per_addr  <= per_base;
      row_adv_q <= ADDR_W'(row_bytes) + ADDR_W'(line_gap);
      unit_q    <= size_bytes(unit_code);
      pstep_q   <= per_inc_en ? size_bytes(per_step_code) : 3'd0;
      bpr_q     <= beats_per_row;
      col_left  <= beats_per_row;
      rows_left <= rows;
    end else if (step) begin
      per_addr <= per_addr + ADDR_W'(pstep_q);
      if (row_wrap) begin
        row_start <= next_row;
        mem_addr  <= next_row;
        col_left  <= bpr_q;
        rows_left <= rows_left - ROWS_W'(1);
      end else begin
        mem_addr <= mem_addr + ADDR_W'(unit_q);
        col_left <= col_left - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dma2d_pacer.sv
module dma2d_pacer #(
  parameter int DLY_UNIT     = 256,
  parameter int DLY_CODE_W   = 3,
  parameter int BURST_CODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    fire,
  input  logic                    last_beat,
  input  logic [BURST_CODE_W-1:0] burst_code,
  input  logic [DLY_CODE_W-1:0]   delay_code,
  output logic                    waiting,
  output logic                    burst_end,
  output logic                    gap_armed
);
  import dma2d_pkg::*;

  localparam int DLY_W  = DLY_CODE_W + $clog2(DLY_UNIT) + 1;
  localparam int BLEN_W = BURST_CODE_W + 1;

  logic [BLEN_W-1:0]     blen_q, bcnt;
  logic [DLY_CODE_W-1:0] dly_q;
  logic [DLY_W-1:0]      dcnt, gap_len;

  generate
    if (DLY_UNIT == (1 << $clog2(DLY_UNIT))) begin : g_shift
      assign gap_len = DLY_W'(dly_q) << $clog2(DLY_UNIT);
    end else begin : g_mult
      assign gap_len = DLY_W'(dly_q) * DLY_W'(DLY_UNIT);
    end
  endgenerate

  assign waiting   = (dcnt != '0);
  assign gap_armed = (dly_q != '0);
  assign burst_end = fire && !last_beat && (bcnt == blen_q - BLEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= BLEN_W'(1);
      dly_q  <= '0;
      bcnt   <= '0;
      dcnt   <= '0;
    end else if (load) begin
      blen_q <= BLEN_W'(burst_beats(3'(burst_code)));
      dly_q  <= delay_code;
      bcnt   <= '0;
      dcnt   <= '0;
    end else if (fire) begin
      if (burst_end) begin
        bcnt <= '0;
        dcnt <= gap_len;
      end else if (last_beat) begin
        bcnt <= '0;
      end else begin
        bcnt <= bcnt + BLEN_W'(1);
      end
    end else if (waiting) begin
      dcnt <= dcnt - DLY_W'(1);
    end
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int ROWS_W   = 12,
  parameter int GAP_W    = 16,
  parameter int DLY_UNIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_2d,
  input  logic [1:0]        unit_code,
  input  logic              per_inc_en,
  input  logic [1:0]        per_step_code,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [ROWS_W-1:0] row_count,
  input  logic [LEN_W-1:0]  row_bytes,
  input  logic [GAP_W-1:0]  line_gap,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] per_base,
  input  logic [2:0]        delay_code,
  input  logic [2:0]        burst_code,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] per_addr,
  output logic              done
);
  import dma2d_pkg::*;

  logic [LEN_W-1:0]  row_beats;
  logic [ROWS_W-1:0] row_total;
  logic empty, accept, load, fire;
  logic active, done_q;
  logic last_beat, row_wrap, per_static;
  logic waiting, burst_end, gap_armed;

  always_comb begin
    row_beats = mode_2d ? LEN_W'(beats_for_bytes(32'(row_bytes), unit_code)) : xfer_len;
    row_total = mode_2d ? row_count : ROWS_W'(1);
  end

  assign empty      = (row_beats == '0) || (row_total == '0);
  assign accept     = start && !active;
  assign load       = accept && !empty;
  assign beat_valid = active && !waiting;
  assign fire       = beat_valid && beat_ready;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (accept && empty) || (fire && last_beat);
      if (load)                   active <= 1'b1;
      else if (fire && last_beat) active <= 1'b0;
    end
  end

  dma2d_walker #(
    .ADDR_W(ADDR_W), .CNT_W(LEN_W), .ROWS_W(ROWS_W), .GAP_W(GAP_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
    .unit_code(unit_code), .per_inc_en(per_inc_en), .per_step_code(per_step_code),
    .beats_per_row(row_beats), .rows(row_total), .row_bytes(row_bytes),
    .line_gap(line_gap), .mem_base(mem_base), .per_base(per_base),
    .mem_addr(mem_addr), .per_addr(per_addr), .last_beat(last_beat),
    .row_wrap(row_wrap), .per_static(per_static)
  );

  dma2d_pacer #(
    .DLY_UNIT(DLY_UNIT), .DLY_CODE_W(3), .BURST_CODE_W(3)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(load), .fire(fire), .last_beat(last_beat),
    .burst_code(burst_code), .delay_code(delay_code),
    .waiting(waiting), .burst_end(burst_end), .gap_armed(gap_armed)
  );

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] per_addr,
  input logic              done,
  input logic              fire,
  input logic              last_beat,
  input logic              burst_end,
  input logic              gap_armed,
  input logic              per_static
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(mem_addr) && $stable(per_addr)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_beat) |=> done);

  assert_done_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  assert_per_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_static) |=> $stable(per_addr));

  assert_gap_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && gap_armed) |=> !beat_valid);

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .mem_addr(mem_addr), .per_addr(per_addr), .done(done), .fire(fire),
  .last_beat(last_beat), .burst_end(burst_end), .gap_armed(gap_armed),
  .per_static(per_static)
);

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mode_2d = 1'b0, per_inc_en = 1'b0, beat_ready = 1'b0;
  logic [1:0]  unit_code = '0, per_step_code = '0;
  logic [15:0] xfer_len = '0, row_bytes = '0, line_gap = '0;
  logic [11:0] row_count = '0;
  logic [31:0] mem_base = '0, per_base = '0;
  logic [2:0]  delay_code = '0, burst_code = '0;
  wire         beat_valid, done;
  wire  [31:0] mem_addr, per_addr;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen i_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_2d(mode_2d),
    .unit_code(unit_code), .per_inc_en(per_inc_en), .per_step_code(per_step_code),
    .xfer_len(xfer_len), .row_count(row_count), .row_bytes(row_bytes),
    .line_gap(line_gap), .mem_base(mem_base), .per_base(per_base),
    .delay_code(delay_code), .burst_code(burst_code), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .mem_addr(mem_addr), .per_addr(per_addr), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input bit m2d, input logic [1:0] uc, input bit pin,
                     input logic [1:0] psc, input int len, input int rows,
                     input int rb, input int gap, input logic [31:0] mb,
                     input logic [31:0] pb, input int dly, input int bc,
                     input bit stall, input bit inject);
    logic [31:0] qm[$];
    logic [31:0] qp[$];
    int qg[$];
    int w, st, bpr, nr, bl, k, idle, cyc, fires, exp_beats;
    bit due, seen, pv;
    logic [31:0] pm, pp;
    string mtag, ptag;
    w  = (uc == 2'd0) ? 4 : (uc == 2'd1) ? 2 : 1;
    st = pin ? ((psc == 2'd0) ? 4 : (psc == 2'd1) ? 2 : 1) : 0;
    if (m2d) begin bpr = (rb + w - 1) / w; nr = rows; end
    else     begin bpr = len; nr = 1; end
    bl = (bc == 0) ? 1 : bc;
    k = 0;
    for (int r = 0; r < nr; r++) begin
      for (int j = 0; j < bpr; j++) begin
        qm.push_back(mb + 32'(r * (rb + gap) + j * w));
        qp.push_back(pb + 32'(k * st));
        qg.push_back((k > 0 && (k % bl) == 0) ? dly * 256 : 0);
        k++;
      end
    end
    exp_beats = k;
    mtag = m2d ? "R3" : "R1";
    ptag = pin ? "R4" : "R5";
    @(negedge clk);
    mode_2d = m2d; unit_code = uc; per_inc_en = pin; per_step_code = psc;
    xfer_len = 16'(len); row_count = 12'(rows); row_bytes = 16'(rb);
    line_gap = 16'(gap); mem_base = mb; per_base = pb;
    delay_code = 3'(dly); burst_code = 3'(bc); start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    due = (exp_beats == 0); seen = 0; pv = 0; idle = 0; cyc = 0; fires = 0;
    forever begin
      if (due) begin
        chk(done === 1'b1 && beat_valid === 1'b0, exp_beats == 0 ? "R9" : "R8",
            "done pulse after final beat", {62'd0, done, beat_valid}, 64'h2);
        break;
      end
      if (done === 1'b1) chk(0, "R8", "done before final beat", 1, 0);
      if (pv) chk(beat_valid === 1'b1 && mem_addr === pm && per_addr === pp, "R7",
                  "stalled beat not held", mem_addr, pm);
      pv = 0;
      if (beat_valid === 1'b1) begin
        if (qm.size() == 0) begin chk(0, "R2", "extra beat", mem_addr, 0); break; end
        if (!seen) begin
          chk(idle == qg[0], "R6", "idle cycles before beat", 64'(idle), 64'(qg[0]));
          seen = 1;
        end
        beat_ready = stall ? ((cyc % 5) < 3) : 1'b1;
        if (beat_ready) begin
          chk(mem_addr === qm[0], mtag, "memory address", mem_addr, qm[0]);
          chk(per_addr === qp[0], ptag, "peripheral address", per_addr, qp[0]);
          void'(qm.pop_front()); void'(qp.pop_front()); void'(qg.pop_front());
          fires++; seen = 0; idle = 0;
          if (qm.size() == 0) due = 1;
        end else begin
          pv = 1; pm = mem_addr; pp = per_addr;
        end
      end else begin
        beat_ready = 1'b0;
        idle++;
      end
      if (inject && cyc == 2) begin mem_base = 32'hdead_0000; start = 1'b1; end
      if (inject && cyc == 3) start = 1'b0;
      cyc++;
      if (cyc > 20000) begin chk(0, "R8", "watchdog expired", 64'(cyc), 0); break; end
      @(negedge clk);
    end
    beat_ready = 1'b0; start = 1'b0;
    chk(fires == exp_beats, inject ? "R10" : "R2", "beat count", 64'(fires), 64'(exp_beats));
    @(negedge clk);
    chk(beat_valid === 1'b0 && done === 1'b0, exp_beats == 0 ? "R9" : "R8",
        "quiet after completion", {62'd0, done, beat_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(beat_valid === 1'b0 && done === 1'b0, "R11", "reset outputs",
        {62'd0, done, beat_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid === 1'b0 && done === 1'b0, "R11", "idle after reset",
        {62'd0, done, beat_valid}, 0);
    // R1 R6: linear words, burst code 0 with one-unit delay between every beat
    run(0, 2'd0, 1, 2'd0, 5, 0, 0, 0, 32'h1000_0000, 32'h0000_0400, 1, 0, 0, 0);
    // R1 R4: linear bytes, step 1, bursts of 2, stalling consumer
    run(0, 2'd2, 1, 2'd2, 6, 0, 0, 0, 32'h2000_0003, 32'h0000_0800, 1, 2, 1, 0);
    // R2 R3 R5 R10: half words, partial-beat rows, fixed peripheral, injected start
    run(1, 2'd1, 0, 2'd0, 0, 3, 5, 10, 32'h3000_0000, 32'h0000_0c00, 0, 4, 1, 1);
    // R2 R3 R4 R6: word rows, no gap, step 2, bursts of 3, two-unit delay
    run(1, 2'd0, 1, 2'd1, 0, 2, 8, 0, 32'h4000_0100, 32'h0000_1000, 2, 3, 0, 0);
    // R3 R4: byte rows, step 4 across row boundaries, three-unit delay
    run(1, 2'd2, 1, 2'd0, 0, 2, 3, 1, 32'h5000_0000, 32'h0000_2000, 3, 2, 1, 0);
    // R9: empty descriptors
    run(0, 2'd0, 1, 2'd0, 0, 0, 0, 0, 32'h6000_0000, 32'h0, 1, 1, 0, 0);
    run(1, 2'd0, 1, 2'd0, 0, 0, 8, 4, 32'h6100_0000, 32'h0, 1, 1, 0, 0);
    run(1, 2'd1, 1, 2'd0, 0, 3, 0, 4, 32'h6200_0000, 32'h0, 1, 1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule